// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out a processor's entry into a trap or interrupt handler over several clock cycles. A request brings a vector address and, for interrupts, an optional priority level. The block fetches the handler's status word and program counter from the vector table. It builds the new status word and installs it. It then saves the old status word and the old program counter on the stack chosen by the new mode, and finally loads the new program counter and the updated stack pointer.

Memory is reached through a single 16-bit word port with separate read and write strobes and a shared ready signal. Each access holds its address and data until ready is seen. Register updates leave the block as one-cycle write strobes with their values. A bus-error request enters the same sequence at the fixed vector 4 and never overrides the priority field.

Top module: `trap_seq`

## Requirements
- R1: After reset, busy, done, memRd, memWr, pswWe, pcWe and spWe are all low.
- R2: The first memory access is a read at vector+2 and the second a read at vector. Each access keeps its address and strobe until a cycle with memReady high.
- R3: The installed status word equals the table word with bits 13:12 replaced by bits 15:14 of the old status word (curPsw at acceptance). All other bits come from the table, except as R4 states.
- R4: When iplValid is high at acceptance, bits 7:5 of the installed status word equal iplLevel. Otherwise they keep the table value.
- R5: pswWe pulses for exactly one cycle with the new status word on pswOut, after both reads and before any memory write.
- R6: The first write goes to SP-2 with the old status word. The second goes to SP-4 with the old program counter.
- R7: SP is the stack pointer in spBank slot m (bits 16*m+15 : 16*m) where m is bits 15:14 of the new status word. spSel equals m when spWe is high.
- R8: pcWe and spWe pulse together in one cycle after the second write, with pcOut equal to the word read at the vector and spOut equal to SP-4.
- R9: When busErr is high at acceptance, the vector used is 4, no priority override applies, and busErr wins over a simultaneous trapReq.
- R10: busy rises the cycle after acceptance and stays high until completion. Requests seen while busy is high are ignored.
- R11: done pulses high for exactly one cycle at the end of a sequence, and busy is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Trap or interrupt request, sampled while idle |
| trapVector | input | 16 | Vector address of the request |
| iplValid | input | 1 | Apply iplLevel to the new status word |
| iplLevel | input | 3 | Priority level for the override |
| busErr | input | 1 | Bus-error request (vector 4, no override) |
| curPsw | input | 16 | Current status word |
| curPc | input | 16 | Current program counter |
| spBank | input | 64 | Stack pointers, 16 bits per mode, mode 0 lowest |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final cycle of a sequence |
| memAddr | output | 16 | Memory word address |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memWData | output | 16 | Write data |
| memRData | input | 16 | Read data, valid with memReady |
| memReady | input | 1 | Access completes this cycle |
| pswWe | output | 1 | Status word write strobe |
| pswOut | output | 16 | New status word |
| spWe | output | 1 | Stack pointer write strobe |
| spSel | output | 2 | Mode index of the stack pointer written |
| spOut | output | 16 | New stack pointer |
| pcWe | output | 1 | Program counter write strobe |
| pcOut | output | 16 | New program counter |

## Verification
The hardest case to reach is the one where the pushes use a different stack from the one the old mode would choose. The stack is picked from a value that exists only after the first read, so a fault here hides unless the table word carries a mode that differs from the old one. The stimulus table pairs old and table status words with differing mode fields, and gives every spBank slot a distinct value, so that a wrong slot shows up in the write addresses. Memory wait states of several lengths keep the access windows open. A second request injected mid-sequence and a bus error raised together with an ordinary request cover the acceptance rules.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int MODE_HI   = 15;
  localparam int PREV_HI   = 13;
  localparam int IPL_LO    = 5;
  localparam int IPL_W     = 3;
  localparam logic [15:0] TABLE_KEEP = 16'o147777;
  localparam logic [15:0] BUS_ERR_VEC = 16'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDPSW, ST_RDPC, ST_INSTALL,
    ST_PUSHPSW, ST_PUSHPC, ST_LOADPC, ST_DONE
  } seqState_e;

  typedef enum logic [1:0] {A_VEC2, A_VEC, A_SP} addrSel_e;

  typedef struct packed {
    logic     latchReq;
    logic     capPsw;
    logic     capPc;
    logic     loadSp;
    logic     decSp;
    addrSel_e addrSel;
    logic     dataSelPc;
  } strobe_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    trapReq,
  input  logic    busErr,
  input  logic    memReady,
  output strobe_t strb,
  output logic    memRd,
  output logic    memWr,
  output logic    pswWe,
  output logic    pcWe,
  output logic    spWe,
  output logic    busy,
  output logic    done
);
  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.addrSel = A_VEC2;
    memRd = 1'b0;
    memWr = 1'b0;
    pswWe = 1'b0;
    pcWe  = 1'b0;
    spWe  = 1'b0;
    unique case (state)
      ST_IDLE: if (trapReq || busErr) begin
        strb.latchReq = 1'b1;
        nextState = ST_RDPSW;
      end
      ST_RDPSW: begin
        memRd = 1'b1;
        strb.addrSel = A_VEC2;
        if (memReady) begin
          strb.capPsw = 1'b1;
          nextState = ST_RDPC;
        end
      end
      ST_RDPC: begin
        memRd = 1'b1;
        strb.addrSel = A_VEC;
        if (memReady) begin
          strb.capPc = 1'b1;
          nextState = ST_INSTALL;
        end
      end
      ST_INSTALL: begin
        pswWe = 1'b1;
        strb.loadSp = 1'b1;
        nextState = ST_PUSHPSW;
      end
      ST_PUSHPSW: begin
        memWr = 1'b1;
        strb.addrSel = A_SP;
        if (memReady) begin
          strb.decSp = 1'b1;
          nextState = ST_PUSHPC;
        end
      end
      ST_PUSHPC: begin
        memWr = 1'b1;
        strb.addrSel = A_SP;
        strb.dataSelPc = 1'b1;
        if (memReady) nextState = ST_LOADPC;
      end
      ST_LOADPC: begin
        pcWe = 1'b1;
        spWe = 1'b1;
        nextState = ST_DONE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int W      = 16,
  parameter int NMODES = 4,
  localparam int SELW  = $clog2(NMODES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [W-1:0]      trapVector,
  input  logic              iplValid,
  input  logic [IPL_W-1:0]  iplLevel,
  input  logic              busErr,
  input  logic [W-1:0]      curPsw,
  input  logic [W-1:0]      curPc,
  input  logic [NMODES*W-1:0] spBank,
  input  logic [W-1:0]      memRData,
  output logic [W-1:0]      memAddr,
  output logic [W-1:0]      memWData,
  output logic [W-1:0]      newPsw,
  output logic [W-1:0]      newPc,
  output logic [SELW-1:0]   spSel,
  output logic [W-1:0]      spWork
);
  localparam logic [W-1:0] WORD_STEP = W'(2);

  logic [W-1:0]     vecR, oldPswR, oldPcR;
  logic             ovrR;
  logic [IPL_W-1:0] lvlR;
  logic [W-1:0]     builtPsw;

  always_comb begin
    builtPsw = memRData & W'(TABLE_KEEP);
    if (ovrR) builtPsw[IPL_LO +: IPL_W] = lvlR;
    builtPsw[PREV_HI -: 2] = oldPswR[MODE_HI -: 2];
  end

  assign spSel = newPsw[MODE_HI -: SELW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecR <= '0; oldPswR <= '0; oldPcR <= '0; ovrR <= 1'b0; lvlR <= '0;
      newPsw <= '0; newPc <= '0; spWork <= '0;
    end else begin
      if (strb.latchReq) begin
        vecR    <= busErr ? W'(BUS_ERR_VEC) : trapVector;
        ovrR    <= !busErr && iplValid;
        lvlR    <= iplLevel;
        oldPswR <= curPsw;
        oldPcR  <= curPc;
      end
      if (strb.capPsw) newPsw <= builtPsw;
      if (strb.capPc)  newPc  <= memRData;
      if (strb.loadSp) spWork <= spBank[spSel*W +: W] - WORD_STEP;
      if (strb.decSp)  spWork <= spWork - WORD_STEP;
    end
  end

  always_comb begin
    unique case (strb.addrSel)
      A_VEC2:  memAddr = vecR + WORD_STEP;
      A_VEC:   memAddr = vecR;
      default: memAddr = spWork;
    endcase
  end

  assign memWData = strb.dataSelPc ? oldPcR : oldPswR;
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int W      = 16,
  parameter int NMODES = 4,
  localparam int SELW  = $clog2(NMODES)
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                trapReq,
  input  logic [W-1:0]        trapVector,
  input  logic                iplValid,
  input  logic [IPL_W-1:0]    iplLevel,
  input  logic                busErr,
  input  logic [W-1:0]        curPsw,
  input  logic [W-1:0]        curPc,
  input  logic [NMODES*W-1:0] spBank,
  output logic                busy,
  output logic                done,
  output logic [W-1:0]        memAddr,
  output logic                memRd,
  output logic                memWr,
  output logic [W-1:0]        memWData,
  input  logic [W-1:0]        memRData,
  input  logic                memReady,
  output logic                pswWe,
  output logic [W-1:0]        pswOut,
  output logic                spWe,
  output logic [SELW-1:0]     spSel,
  output logic [W-1:0]        spOut,
  output logic                pcWe,
  output logic [W-1:0]        pcOut
);
  strobe_t strb;

  trap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .busErr(busErr),
    .memReady(memReady), .strb(strb), .memRd(memRd), .memWr(memWr),
    .pswWe(pswWe), .pcWe(pcWe), .spWe(spWe), .busy(busy), .done(done)
  );

  trap_dp #(.W(W), .NMODES(NMODES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .trapVector(trapVector),
    .iplValid(iplValid), .iplLevel(iplLevel), .busErr(busErr),
    .curPsw(curPsw), .curPc(curPc), .spBank(spBank), .memRData(memRData),
    .memAddr(memAddr), .memWData(memWData), .newPsw(pswOut),
    .newPc(pcOut), .spSel(spSel), .spWork(spOut)
  );
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk (
  input logic clk,
  input logic rstN,
  input logic trapReq,
  input logic busErr,
  input logic busy,
  input logic done,
  input logic memRd,
  input logic memWr,
  input logic memReady,
  input logic [15:0] memAddr,
  input logic pswWe,
  input logic pcWe,
  input logic spWe
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memRd && !memWr && !pswWe && !pcWe && !spWe);

  p_hold_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) && !memReady |=> (memRd || memWr) && $stable(memAddr));

  p_one_action_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, memWr, pswWe, pcWe}));

  p_install_then_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    pswWe |=> memWr && !pswWe);

  p_pc_with_sp_r8: assert property (@(posedge clk) disable iff (!rstN)
    pcWe |-> spWe);

  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy && (trapReq || busErr) |=> busy);

  p_done_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy ##1 !busy);
endmodule

bind trap_seq trap_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .busErr(busErr), .busy(busy),
  .done(done), .memRd(memRd), .memWr(memWr), .memReady(memReady),
  .memAddr(memAddr), .pswWe(pswWe), .pcWe(pcWe), .spWe(spWe)
);

// File: tb/sim_trap_seq.sv
module sim_trap_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic trapReq = 1'b0, iplValid = 1'b0, busErr = 1'b0, memReady = 1'b0;
  logic [15:0] trapVector = '0, curPsw = '0, curPc = '0, memRData = '0;
  logic [2:0]  iplLevel = '0;
  logic [63:0] spBank = {16'o4000, 16'o3000, 16'o2000, 16'o1000};
  logic busy, done, memRd, memWr, pswWe, spWe, pcWe;
  logic [15:0] memAddr, memWData, pswOut, spOut, pcOut;
  logic [1:0] spSel;

  trap_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;

  // memory model state
  logic [15:0] tVec = '0, tPsw = '0, tPc = '0;
  int waitN = 0, waitCnt = 0;
  int evCnt = 0, doneCnt = 0;
  int evKind[16];
  logic [15:0] evA[16], evD[16], evS[16];

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%o expected=%o", req, act, exp);
    end
  endtask

  task automatic logEv(input int k, input logic [15:0] a, input logic [15:0] d, input logic [15:0] s);
    if (evCnt < 16) begin
      evKind[evCnt] = k; evA[evCnt] = a; evD[evCnt] = d; evS[evCnt] = s;
    end
    evCnt++;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (done) doneCnt++;
      if (pswWe) logEv(3, 16'd0, pswOut, 16'd0);
      if (pcWe)  logEv(4, spOut, pcOut, {14'd0, spSel} | (spWe ? 16'h0 : 16'h8000));
      if ((memRd || memWr) && !memReady) begin
        if (waitCnt < waitN) waitCnt++;
        else begin
          memReady = 1'b1;
          waitCnt = 0;
          memRData = (memAddr == tVec + 16'd2) ? tPsw :
                     (memAddr == tVec) ? tPc : 16'hDEAD;
          logEv(memRd ? 1 : 2, memAddr, memRd ? memRData : memWData, 16'd0);
        end
      end else memReady = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [15:0] expPsw(input logic [15:0] tbl, input logic [15:0] old,
                                         input bit ovr, input logic [2:0] lvl);
    logic [15:0] e;
    e = tbl & 16'o147777;
    if (ovr) e[7:5] = lvl;
    e[13:12] = old[15:14];
    return e;
  endfunction

  typedef struct packed {
    logic [15:0] vec;
    logic        useIpl;
    logic [2:0]  lvl;
    logic [15:0] oldPsw;
    logic [15:0] oldPc;
    logic [15:0] tblPsw;
    logic [15:0] tblPc;
    logic [3:0]  waits;
  } row_t;

  localparam row_t ROWS[5] = '{
    '{16'o220, 1'b1, 3'd5, 16'o170000, 16'o1234, 16'o000340, 16'o5000, 4'd0},
    '{16'o100, 1'b0, 3'd2, 16'o000000, 16'o2222, 16'o177777, 16'o6000, 4'd2},
    '{16'o060, 1'b1, 3'd0, 16'o040017, 16'o3330, 16'o100347, 16'o7000, 4'd1},
    '{16'o374, 1'b0, 3'd0, 16'o140340, 16'o4440, 16'o040017, 16'o1100, 4'd3},
    '{16'o014, 1'b1, 3'd7, 16'o100000, 16'o5550, 16'o140000, 16'o1200, 4'd0}
  };

  task automatic runTrap(input row_t r, input bit be, input bit inject);
    logic [15:0] ev, ep, sp;
    logic [1:0] m;
    bit ovr;
    ovr = r.useIpl && !be;
    tVec = be ? 16'd4 : r.vec;
    tPsw = r.tblPsw; tPc = r.tblPc; waitN = int'(r.waits);
    ep = expPsw(r.tblPsw, r.oldPsw, ovr, r.lvl);
    m = ep[15:14];
    sp = spBank[m*16 +: 16];
    ev = tVec;
    @(negedge clk);
    evCnt = 0; doneCnt = 0;
    trapVector = r.vec; iplValid = r.useIpl; iplLevel = r.lvl;
    curPsw = r.oldPsw; curPc = r.oldPc; busErr = be; trapReq = 1'b1;
    @(negedge clk);
    trapReq = 1'b0; busErr = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", {15'd0, busy}, 16'd1);
    for (int i = 0; i < 300 && busy; i++) begin
      if (inject && i == 2) begin trapReq = 1'b1; trapVector = 16'o444; end
      else trapReq = 1'b0;
      @(negedge clk);
    end
    trapReq = 1'b0;
    chk(doneCnt == 1, "R11 one done pulse", 16'(doneCnt), 16'd1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R10 no restart from request while busy", {15'd0, busy}, 16'd0);
    chk(evCnt == 6, "R10 event count", 16'(evCnt), 16'd6);
    chk(evKind[0] == 1 && evA[0] == ev + 16'd2, "R2 first read at vector+2", evA[0], ev + 16'd2);
    chk(evKind[1] == 1 && evA[1] == ev, "R2 second read at vector", evA[1], ev);
    chk(evKind[2] == 3, "R5 status install before writes", 16'(evKind[2]), 16'd3);
    chk(evD[2][15:8] == ep[15:8] && evD[2][4:0] == ep[4:0], "R3 new status word", evD[2], ep);
    chk(evD[2][7:5] == ep[7:5], "R4 priority field", {13'd0, evD[2][7:5]}, {13'd0, ep[7:5]});
    chk(evKind[3] == 2 && evA[3] == sp - 16'd2, "R7 first push address", evA[3], sp - 16'd2);
    chk(evD[3] == r.oldPsw, "R6 first push data", evD[3], r.oldPsw);
    chk(evKind[4] == 2 && evA[4] == sp - 16'd4, "R6 second push address", evA[4], sp - 16'd4);
    chk(evD[4] == r.oldPc, "R6 second push data", evD[4], r.oldPc);
    chk(evKind[5] == 4 && evD[5] == r.tblPc, "R8 pc load", evD[5], r.tblPc);
    chk(evA[5] == sp - 16'd4, "R8 sp update", evA[5], sp - 16'd4);
    chk(evS[5] == {14'd0, m}, "R7 sp select with write strobe", evS[5], {14'd0, m});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memRd && !memWr, "R1 reset idle outputs",
        {12'd0, busy, done, memRd, memWr}, 16'd0);
    chk(!pswWe && !pcWe && !spWe, "R1 reset strobes", {13'd0, pswWe, pcWe, spWe}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 idle after reset release", {15'd0, busy}, 16'd0);
    for (int k = 0; k < 5; k++) runTrap(ROWS[k], 1'b0, 1'b0);
    // R9: bus error with a simultaneous request carrying an override
    runTrap(ROWS[0], 1'b1, 1'b0);
    // R10: second request raised mid-sequence is dropped
    runTrap(ROWS[2], 1'b0, 1'b1);
    // R2: long wait states on every access
    runTrap('{16'o240, 1'b1, 3'd3, 16'o070000, 16'o7770, 16'o030000, 16'o1300, 4'd9}, 1'b0, 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule